// File: doc/BRIEF.md
# Supply-Fail Access Guard

This block sits between a memory and clock register file and the host bus, and decides from two supply-status levels whether the part may be accessed. One level reports that the main supply is above the write-protect threshold. The other reports that the supply is above the backup cell voltage. Both levels are produced by analog comparators outside this block. They reach the block asynchronously and pass through a two-stage synchroniser before any decision uses them.

While the synchronised supply is out of tolerance, the block blocks every read and write and holds its reset output active. When the supply returns, the reset output is held for a recovery period. That period is counted in clock cycles from a frequency parameter and a millisecond parameter, and it starts over if the supply dips again before it expires.

The power-source select output asks for the backup source only when the supply is below both thresholds. A one-time arming latch keeps the backup source disconnected until the supply has been seen in tolerance once. Only a dedicated factory-clear input disarms that latch. The ordinary reset leaves it alone.

Top module: `pwr_guard_ctrl`

## Requirements
- R1: A change on `sup_ok_wp_i` appears on `acc_en_o` after exactly two rising clock edges (two-stage synchroniser).
- R2: While the synchronised supply-ok level is 0, `acc_en_o`, `rd_en_o` and `wr_en_o` are all 0, whatever the request inputs are.
- R3: While the synchronised supply-ok level is 1, `acc_en_o` is 1, `wr_en_o` equals `wr_req_i`, and `rd_en_o` equals `rd_req_i` AND NOT `wr_req_i` (a write suppresses the read), so the two are never 1 together.
- R4: `rst_o` is 1 in every cycle in which `acc_en_o` is 0. It rises in the same cycle that `acc_en_o` falls.
- R5: After the synchronised supply-ok level rises, `rst_o` stays 1 for REC_CYC = CLK_FREQ_KHZ*RECOVER_MS further rising edges and is 0 from the edge after that, as long as the supply stays ok.
- R6: If the synchronised supply-ok level drops before the recovery count expires, the count restarts in full at the next rise.
- R7: `bkup_sel_o` is 1 only when the block is armed and both synchronised levels (supply above write-protect, supply above backup voltage) are 0. It is 0 if either level is 1.
- R8: The arming latch sets on the first cycle in which the synchronised supply-ok level is 1. Until then `bkup_sel_o` stays 0 in every supply state.
- R9: `rst_n` does not disarm the latch. Only `fact_clr_n` low clears it, asynchronously.
- R10: With `rst_n` and `fact_clr_n` both low, `acc_en_o`=0, `rd_en_o`=0, `wr_en_o`=0, `rst_o`=1 and `bkup_sel_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| fact_clr_n | input | 1 | Active-low factory clear of the backup arming latch |
| sup_ok_wp_i | input | 1 | Asynchronous: supply above the write-protect threshold |
| sup_gt_bat_i | input | 1 | Asynchronous: supply above the backup cell voltage |
| rd_req_i | input | 1 | Host read request |
| wr_req_i | input | 1 | Host write request |
| acc_en_o | output | 1 | Access allowed (chip selected) |
| rd_en_o | output | 1 | Gated read strobe / data output drive enable |
| wr_en_o | output | 1 | Gated write strobe |
| rst_o | output | 1 | Power-fail reset, active high |
| bkup_sel_o | output | 1 | Request to power from the backup source |

## Verification
The risky overlap is a supply failure in the same cycle that a write is requested. The access gate must close on exactly the cycle the reset output asserts, so that no write strobe leaves alongside an active reset. The bench holds a write request and drops the supply input, then checks `acc_en_o`, `wr_en_o` and `rst_o` together on the edge where the synchronised level changes. A second overlap is a supply dip that lands in the middle of a recovery count. This is provoked with a one-cycle low pulse on the supply input. The bench judges it by `rst_o` still being high one cycle before the restarted count can expire, and low exactly at expiry.

// File: rtl/pwr_guard_pkg.sv
`timescale 1ns/1ps
package pwr_guard_pkg;
  // Depth of the input synchroniser chain
  localparam int SYNC_DEPTH = 2;

  // Digitised supply comparator levels
  typedef struct packed {
    logic above_bat;
    logic above_wp;
  } sup_stat_t;

  localparam int STAT_W = $bits(sup_stat_t);
endpackage

// File: rtl/pwr_guard_sync.sv
`timescale 1ns/1ps
module pwr_guard_sync #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [DEPTH];

  // Reset value 0 reads as "supply out of tolerance"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < DEPTH; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/pwr_guard_recover.sv
`timescale 1ns/1ps
module pwr_guard_recover #(
  parameter int CNT_MAX = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_max;

  assign at_max = (cnt_q == CNT_W'(CNT_MAX));

  // Clear while the supply is bad, count up while good, hold at the limit
  always_comb begin
    cnt_en = !ok_i || !at_max;
    cnt_d  = ok_i ? (cnt_q + CNT_W'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = at_max;
endmodule

// File: rtl/pwr_guard_fresh.sv
`timescale 1ns/1ps
module pwr_guard_fresh (
  input  logic clk,
  input  logic fact_clr_n,
  input  logic above_wp_i,
  input  logic above_bat_i,
  output logic bkup_sel_o
);
  logic armed_q;
  logic arm_en;

  // One-time set on the first in-tolerance cycle
  always_comb arm_en = above_wp_i && !armed_q;

  // Only the factory clear disarms; the ordinary reset is not connected
  always_ff @(posedge clk or negedge fact_clr_n) begin
    if (!fact_clr_n)  armed_q <= 1'b0;
    else if (arm_en)  armed_q <= 1'b1;
  end

  // Switch over below the lower of the two thresholds
  assign bkup_sel_o = armed_q && !above_wp_i && !above_bat_i;
endmodule

// File: rtl/pwr_guard_ctrl.sv
`timescale 1ns/1ps
module pwr_guard_ctrl
  import pwr_guard_pkg::*;
#(
  parameter int CLK_FREQ_KHZ = 50000,
  parameter int RECOVER_MS   = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fact_clr_n,
  input  logic sup_ok_wp_i,
  input  logic sup_gt_bat_i,
  input  logic rd_req_i,
  input  logic wr_req_i,
  output logic acc_en_o,
  output logic rd_en_o,
  output logic wr_en_o,
  output logic rst_o,
  output logic bkup_sel_o
);
  localparam int REC_CYC = CLK_FREQ_KHZ * RECOVER_MS;

  sup_stat_t raw_stat, syn_stat;
  logic      rec_done;

  assign raw_stat.above_wp  = sup_ok_wp_i;
  assign raw_stat.above_bat = sup_gt_bat_i;

  pwr_guard_sync #(
    .WIDTH (STAT_W),
    .DEPTH (SYNC_DEPTH)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_stat),
    .q_o   (syn_stat)
  );

  pwr_guard_recover #(
    .CNT_MAX (REC_CYC)
  ) u_recover (
    .clk    (clk),
    .rst_n  (rst_n),
    .ok_i   (syn_stat.above_wp),
    .done_o (rec_done)
  );

  pwr_guard_fresh u_fresh (
    .clk         (clk),
    .fact_clr_n  (fact_clr_n),
    .above_wp_i  (syn_stat.above_wp),
    .above_bat_i (syn_stat.above_bat),
    .bkup_sel_o  (bkup_sel_o)
  );

  // Gate decisions follow the synchronised level in the same cycle
  always_comb begin
    acc_en_o = syn_stat.above_wp;
    wr_en_o  = acc_en_o && wr_req_i;
    rd_en_o  = acc_en_o && rd_req_i && !wr_req_i;
    rst_o    = !syn_stat.above_wp || !rec_done;
  end
endmodule

// File: rtl/pwr_guard_chk.sv
`timescale 1ns/1ps
module pwr_guard_chk #(
  parameter int CLK_FREQ_KHZ = 50000,
  parameter int RECOVER_MS   = 35
) (
  input logic clk,
  input logic rst_n,
  input logic sup_ok_wp_i,
  input logic acc_en_o,
  input logic rd_en_o,
  input logic wr_en_o,
  input logic rst_o,
  input logic bkup_sel_o
);
  localparam int REC_CYC = CLK_FREQ_KHZ * RECOVER_MS;
  localparam int UP_W    = $clog2(REC_CYC + 1);

  logic [1:0]      cyc_q;
  logic [UP_W-1:0] up_q;

  // Edges seen since reset release, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  // Consecutive cycles with access enabled, saturating at the recovery length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        up_q <= '0;
    else if (!acc_en_o)                up_q <= '0;
    else if (up_q != UP_W'(REC_CYC))   up_q <= up_q + UP_W'(1);
  end

  p_sync_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> (acc_en_o == $past(sup_ok_wp_i, 2)));

  p_gate_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en_o |-> (!rd_en_o && !wr_en_o));

  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_o && wr_en_o));

  p_rst_on_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en_o |-> rst_o);

  p_rec_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_o |-> (up_q == UP_W'(REC_CYC)));

  p_bkup_only_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bkup_sel_o |-> (!acc_en_o && rst_o));
endmodule

bind pwr_guard_ctrl pwr_guard_chk #(
  .CLK_FREQ_KHZ (CLK_FREQ_KHZ),
  .RECOVER_MS   (RECOVER_MS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sup_ok_wp_i (sup_ok_wp_i),
  .acc_en_o    (acc_en_o),
  .rd_en_o     (rd_en_o),
  .wr_en_o     (wr_en_o),
  .rst_o       (rst_o),
  .bkup_sel_o  (bkup_sel_o)
);

// File: tb/pwr_guard_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_guard_ctrl_tb_top;
  localparam int KHZ = 1;
  localparam int MS  = 35;
  localparam int REC = KHZ * MS;

  // {ok, bat, rd, wr, exp_acc, exp_rd, exp_wr, exp_bkup}; device already armed
  localparam logic [7:0] VEC [8] = '{
    8'b1110_1100,
    8'b1101_1010,
    8'b1111_1010,
    8'b1010_1100,
    8'b0111_0000,
    8'b0010_0001,
    8'b0001_0001,
    8'b1100_1000
  };

  logic clk = 1'b0;
  logic rst_n, fact_clr_n, sup_ok_wp_i, sup_gt_bat_i, rd_req_i, wr_req_i;
  logic acc_en_o, rd_en_o, wr_en_o, rst_o, bkup_sel_o;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pwr_guard_ctrl #(.CLK_FREQ_KHZ(KHZ), .RECOVER_MS(MS)) dut_i (
    .clk (clk), .rst_n (rst_n), .fact_clr_n (fact_clr_n),
    .sup_ok_wp_i (sup_ok_wp_i), .sup_gt_bat_i (sup_gt_bat_i),
    .rd_req_i (rd_req_i), .wr_req_i (wr_req_i),
    .acc_en_o (acc_en_o), .rd_en_o (rd_en_o), .wr_en_o (wr_en_o),
    .rst_o (rst_o), .bkup_sel_o (bkup_sel_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic ok, input logic bat);
    sup_ok_wp_i  = ok;
    sup_gt_bat_i = bat;
  endtask

  initial begin
    rst_n = 1'b0; fact_clr_n = 1'b0;
    drive(1'b0, 1'b0); rd_req_i = 1'b0; wr_req_i = 1'b0;
    tick(3);
    // R10 reset state
    chk("R10", "acc_en", acc_en_o, 1'b0);
    chk("R10", "rd_en", rd_en_o, 1'b0);
    chk("R10", "wr_en", wr_en_o, 1'b0);
    chk("R10", "rst", rst_o, 1'b1);
    chk("R10", "bkup", bkup_sel_o, 1'b0);
    rst_n = 1'b1; fact_clr_n = 1'b1;
    tick(5);
    // R8 never powered up: no backup even below both thresholds
    chk("R8", "bkup unarmed", bkup_sel_o, 1'b0);

    // R1 two-edge latency, R4 reset held, R5 recovery length; write held (R2)
    wr_req_i = 1'b1;
    drive(1'b1, 1'b1);
    tick(1);
    chk("R1", "acc after 1 edge", acc_en_o, 1'b0);
    chk("R2", "wr blocked", wr_en_o, 1'b0);
    tick(1);
    chk("R1", "acc after 2 edges", acc_en_o, 1'b1);
    chk("R3", "wr passes", wr_en_o, 1'b1);
    chk("R5", "rst at rise", rst_o, 1'b1);
    tick(REC - 1);
    chk("R5", "rst one before expiry", rst_o, 1'b1);
    tick(1);
    chk("R5", "rst released", rst_o, 1'b0);
    wr_req_i = 1'b0;

    // Table walk: R2, R3, R7
    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][7], VEC[i][6]);
      rd_req_i = VEC[i][5];
      wr_req_i = VEC[i][4];
      tick(3);
      chk("R2/R3", $sformatf("vec%0d acc", i), acc_en_o, VEC[i][3]);
      chk("R3", $sformatf("vec%0d rd", i), rd_en_o, VEC[i][2]);
      chk("R3", $sformatf("vec%0d wr", i), wr_en_o, VEC[i][1]);
      chk("R7", $sformatf("vec%0d bkup", i), bkup_sel_o, VEC[i][0]);
    end

    // Fail while a write is requested: gate and reset switch together (R4)
    tick(REC + 5);
    chk("R5", "rst low steady", rst_o, 1'b0);
    wr_req_i = 1'b1;
    drive(1'b0, 1'b1);
    tick(1);
    chk("R4", "acc before sync", acc_en_o, 1'b1);
    chk("R4", "rst before sync", rst_o, 1'b0);
    tick(1);
    chk("R4", "acc dropped", acc_en_o, 1'b0);
    chk("R4", "wr dropped", wr_en_o, 1'b0);
    chk("R4", "rst same cycle", rst_o, 1'b1);
    wr_req_i = 1'b0;

    // R6 dip in mid-recovery restarts the count
    drive(1'b1, 1'b1);
    tick(2 + REC / 2);
    drive(1'b0, 1'b1);
    tick(1);
    drive(1'b1, 1'b1);
    tick(1 + REC);
    chk("R6", "rst held after restart", rst_o, 1'b1);
    tick(1);
    chk("R6", "rst released after full count", rst_o, 1'b0);

    // R9 ordinary reset keeps the arming
    drive(1'b0, 1'b0);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
    chk("R9", "armed kept over rst_n", bkup_sel_o, 1'b1);
    fact_clr_n = 1'b0;
    tick(1);
    fact_clr_n = 1'b1;
    tick(1);
    chk("R9", "factory clear disarms", bkup_sel_o, 1'b0);
    drive(1'b0, 1'b1);
    tick(3);
    chk("R8", "unarmed above battery", bkup_sel_o, 1'b0);
    drive(1'b0, 1'b0);
    tick(3);
    chk("R8", "unarmed below both", bkup_sel_o, 1'b0);
    drive(1'b1, 1'b1);
    tick(3);
    drive(1'b0, 1'b0);
    tick(3);
    chk("R8", "armed by first power-up", bkup_sel_o, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule